// File: doc/BRIEF.md
# Interrupt Claim-Complete Controller

This block collects level-sensitive interrupt requests from a set of numbered sources and delivers them to a small number of processor contexts. Each source has a gateway. The gateway turns an asserted level into a latched pending bit. It then keeps the source out of arbitration while the source is in service. Each source has a priority. Each context has its own enable mask and priority threshold. For every context, an arbiter picks the best pending source that the context has enabled. If that source's priority is above the context's threshold, the arbiter raises the context's interrupt line.

Software works through a simple strobe-driven register port. A read from a context's claim register returns the best source ID and moves that source into service in the same cycle. Writing the ID back to the same register completes the interrupt, but only when that source is enabled for the writing context. The `auto_mask_i` input selects the claim behaviour. In standard mode a claim leaves the enables alone. In auto-mask mode a claim also clears the claimed source's enable bit for that context. Software must therefore re-enable the source before its completion is accepted. Otherwise the source stays in service for good.

The register port has no back-pressure. A read or a write is accepted in the cycle its strobe is high. Read data is valid combinationally in that same cycle. Register side effects take place at the clock edge that ends the cycle. The port has no valid/ready pair, so the block can never stall. A read and a write may occur in the same cycle.

Top module: `irq_claim_ctrl`

## Requirements
- R1: After reset, all priorities, enables, thresholds, pending bits and in-service bits are zero, every `irq_o` bit is low, and a claim read returns 0.
- R2: A claim read of context c returns the ID of the pending source enabled in c with the highest priority. On a tie in priority the lowest ID wins. When no source qualifies, the read returns 0.
- R3: A source whose priority is 0 is never returned by a claim and never raises `irq_o`, even while it is pending.
- R4: At the edge that ends a non-zero claim read, the returned source's pending bit clears and its in-service bit sets. While the source is in service it does not become pending again, even with its level held high.
- R5: A completion write with an ID that is enabled for the writing context clears that source's in-service bit. If the source level is still high, the pending bit sets at the following edge, not at the completion edge.
- R6: A completion write is ignored, and the in-service bits do not change, in any of these cases: the ID is 0, the full write data is above the number of sources, or the ID is not enabled for the writing context.
- R7: When `auto_mask_i` is 1, a claim also clears the claimed source's enable bit for the claiming context. When `auto_mask_i` is 0, a claim changes no enable bit.
- R8: A source whose enable was cleared by auto-mask stays in service through completion attempts. Its completion is accepted once the enable bit has been written back to 1.
- R9: `irq_o[c]` is high exactly when the best priority for context c is strictly greater than the threshold of context c.
- R10: The in-service state belongs to the source, not to a context. A source claimed through one context is offered to no context. Other sources stay deliverable to every context, and any context that has the source enabled may complete it.
- R11: The register map is decoded from address bits [7:5], and address bits [4:0] select the index.
  - Region 0 holds priority s at address s. Address 0 reads 0 and ignores writes, and only the low 3 bits are stored.
  - Region 1 holds the enable mask of context c at 0x20+c, with bit s meaning source s. Bit 0 always reads 0.
  - Region 2 holds the threshold of context c at 0x40+c.
  - Region 3 holds the claim/complete register of context c at 0x60+c.
  - In region 4, address 0x80 returns the pending bits and address 0x81 returns the in-service bits, with bit s meaning source s.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| auto_mask_i | input | 1 | 1 selects auto-mask on claim; 0 selects standard mode |
| src_i | input | NUM_SRC (bits NUM_SRC:1) | Level interrupt request; bit s belongs to source s |
| reg_rd_i | input | 1 | Read strobe, accepted in the cycle it is high |
| reg_wr_i | input | 1 | Write strobe, accepted in the cycle it is high |
| reg_addr_i | input | 8 | Register address |
| reg_wdata_i | input | DATA_W | Write data |
| reg_rdata_o | output | DATA_W | Read data, valid in the same cycle as the read strobe |
| irq_o | output | NUM_CTX | Interrupt request per context |

## Verification
Some rules are checked on every cycle by the assertions:
- a claim empties the pending bit and sets the in-service bit;
- an in-service source never re-pends before it is completed;
- a rejected completion leaves the in-service bits untouched;
- auto-mask clears exactly the claimed enable, and standard mode touches no enable;
- the arbiter's pick is always pending, enabled and of non-zero priority.

Other behaviours depend on ordering, so only the bench's scenarios can show them:
- the tie-break toward the lowest ID;
- the one-edge delay before a held level re-pends;
- the stuck source after auto-mask, and its release once software re-enables it;
- the sharing of in-service state across contexts.

// File: rtl/icc_pkg.sv
package icc_pkg;

  localparam int ADDR_W = 8;

  // Register regions, selected by address bits [7:5].
  typedef enum logic [2:0] {
    RG_PRIO  = 3'd0,
    RG_EN    = 3'd1,
    RG_THR   = 3'd2,
    RG_CLAIM = 3'd3,
    RG_STAT  = 3'd4,
    RG_NONE5 = 3'd5,
    RG_NONE6 = 3'd6,
    RG_NONE7 = 3'd7
  } region_e;

endpackage

// File: rtl/icc_gateway.sv
// One source: level capture into pending, then in-service until completion.
module icc_gateway (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic level_i,
  input  logic claim_i,
  input  logic complete_i,
  output logic pending_o,
  output logic claimed_o
);

  logic pending_q, claimed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pending_q <= 1'b0;
      claimed_q <= 1'b0;
    end else if (claim_i) begin
      pending_q <= 1'b0;
      claimed_q <= 1'b1;
    end else if (complete_i) begin
      claimed_q <= 1'b0;
    end else if (!pending_q && !claimed_q && level_i) begin
      pending_q <= 1'b1;
    end
  end

  assign pending_o = pending_q;
  assign claimed_o = claimed_q;

  // R4: a claim moves the source from pending into service
  a_r4_claim_moves_to_service: assert property (@(posedge clk_i) disable iff (!rst_ni)
    claim_i |=> (!pending_q && claimed_q));

  // R4: no re-pend while in service and not completed
  a_r4_no_repend_in_service: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (claimed_q && !complete_i) |=> !pending_q);

  // R5: an accepted completion ends service
  a_r5_complete_releases: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (complete_i && claimed_q && !claim_i) |=> !claimed_q);

endmodule

// File: rtl/icc_arbiter.sv
// Per-context selection: highest priority among pending and enabled sources.
// A strict compare gives ties to the lowest ID and never picks priority 0.
module icc_arbiter #(
  parameter int NUM_SRC = 31,
  parameter int PRIO_W  = 3,
  localparam int ID_W   = $clog2(NUM_SRC + 1)
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [NUM_SRC:0]              pending_i,
  input  logic [NUM_SRC:0]              enable_i,
  input  logic [NUM_SRC:0][PRIO_W-1:0]  prio_i,
  output logic [ID_W-1:0]               best_id_o,
  output logic [PRIO_W-1:0]             best_prio_o
);

  always_comb begin
    best_id_o   = '0;
    best_prio_o = '0;
    for (int i = 0; i <= NUM_SRC; i++) begin
      if (pending_i[i] && enable_i[i] && (prio_i[i] > best_prio_o)) begin
        best_id_o   = ID_W'(i);
        best_prio_o = prio_i[i];
      end
    end
  end

  // R2/R3: the chosen source is pending, enabled and of non-zero priority
  a_r2_pick_is_eligible: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (best_id_o != '0) |-> (pending_i[best_id_o] && enable_i[best_id_o]
                           && prio_i[best_id_o] != '0));

endmodule

// File: rtl/irq_claim_ctrl.sv
module irq_claim_ctrl
  import icc_pkg::*;
#(
  parameter int NUM_SRC = 31,
  parameter int NUM_CTX = 2,
  parameter int PRIO_W  = 3,
  parameter int DATA_W  = 32,
  localparam int ID_W   = $clog2(NUM_SRC + 1),
  localparam int CTX_W  = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  auto_mask_i,
  input  logic [NUM_SRC:1]      src_i,
  input  logic                  reg_rd_i,
  input  logic                  reg_wr_i,
  input  logic [ADDR_W-1:0]     reg_addr_i,
  input  logic [DATA_W-1:0]     reg_wdata_i,
  output logic [DATA_W-1:0]     reg_rdata_o,
  output logic [NUM_CTX-1:0]    irq_o
);

  initial begin
    if (NUM_SRC > 31 || NUM_SRC + 1 > DATA_W || NUM_CTX > 32)
      $error("irq_claim_ctrl: unsupported parameter set");
  end

  // ---------------- decode ----------------
  region_e           region;
  logic [4:0]        idx;
  logic [CTX_W-1:0]  ctx_idx;
  logic              ctx_ok, src_idx_ok;

  assign region     = region_e'(reg_addr_i[7:5]);
  assign idx        = reg_addr_i[4:0];
  assign ctx_idx    = CTX_W'(idx);
  assign ctx_ok     = (32'(idx) < NUM_CTX);
  assign src_idx_ok = (idx != 5'd0) && (32'(idx) <= NUM_SRC);

  // ---------------- state ----------------
  logic [NUM_SRC:0][PRIO_W-1:0]  prio_q;
  logic [NUM_CTX-1:0][NUM_SRC:0] en_q;
  logic [NUM_CTX-1:0][PRIO_W-1:0] thr_q;
  logic [NUM_SRC:0]              pending_vec, claimed_vec;

  logic [NUM_CTX-1:0][ID_W-1:0]   best_id;
  logic [NUM_CTX-1:0][PRIO_W-1:0] best_prio;

  // ---------------- claim / complete ----------------
  logic            claim_fire;
  logic [ID_W-1:0] claim_id;
  logic            wr_claim, cmpl_range_ok, cmpl_ok;
  logic [ID_W-1:0] cmpl_id;
  logic            en_wr;

  assign claim_id      = best_id[ctx_idx];
  assign claim_fire    = reg_rd_i && (region == RG_CLAIM) && ctx_ok && (claim_id != '0);
  assign wr_claim      = reg_wr_i && (region == RG_CLAIM) && ctx_ok;
  assign cmpl_id       = reg_wdata_i[ID_W-1:0];
  assign cmpl_range_ok = (reg_wdata_i != '0) && (reg_wdata_i <= DATA_W'(NUM_SRC));
  assign cmpl_ok       = wr_claim && cmpl_range_ok && en_q[ctx_idx][cmpl_id];
  assign en_wr         = reg_wr_i && (region == RG_EN) && ctx_ok;

  // ---------------- gateways ----------------
  assign pending_vec[0] = 1'b0;
  assign claimed_vec[0] = 1'b0;

  for (genvar g = 1; g <= NUM_SRC; g++) begin : g_gw
    icc_gateway u_gw (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .level_i    (src_i[g]),
      .claim_i    (claim_fire && (claim_id == ID_W'(g))),
      .complete_i (cmpl_ok && (cmpl_id == ID_W'(g))),
      .pending_o  (pending_vec[g]),
      .claimed_o  (claimed_vec[g])
    );
  end

  // ---------------- arbiters ----------------
  for (genvar c = 0; c < NUM_CTX; c++) begin : g_arb
    icc_arbiter #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) u_arb (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .pending_i   (pending_vec),
      .enable_i    (en_q[c]),
      .prio_i      (prio_q),
      .best_id_o   (best_id[c]),
      .best_prio_o (best_prio[c])
    );
    assign irq_o[c] = (best_prio[c] > thr_q[c]);
  end

  // ---------------- configuration registers ----------------
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prio_q <= '0;
      thr_q  <= '0;
    end else if (reg_wr_i) begin
      if (region == RG_PRIO && src_idx_ok)
        prio_q[idx] <= reg_wdata_i[PRIO_W-1:0];
      if (region == RG_THR && ctx_ok)
        thr_q[ctx_idx] <= reg_wdata_i[PRIO_W-1:0];
    end
  end

  // Enables: software write first, auto-mask clear applied after it.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q <= '0;
    end else begin
      if (en_wr)
        en_q[ctx_idx] <= reg_wdata_i[NUM_SRC:0] & ~(NUM_SRC+1)'(1);
      if (claim_fire && auto_mask_i)
        en_q[ctx_idx][claim_id] <= 1'b0;
    end
  end

  // ---------------- read mux ----------------
  always_comb begin
    reg_rdata_o = '0;
    if (reg_rd_i) begin
      unique case (region)
        RG_PRIO:  if (32'(idx) <= NUM_SRC) reg_rdata_o = DATA_W'(prio_q[idx]);
        RG_EN:    if (ctx_ok) reg_rdata_o = DATA_W'(en_q[ctx_idx]);
        RG_THR:   if (ctx_ok) reg_rdata_o = DATA_W'(thr_q[ctx_idx]);
        RG_CLAIM: if (ctx_ok) reg_rdata_o = DATA_W'(claim_id);
        RG_STAT: begin
          if (idx == 5'd0)      reg_rdata_o = DATA_W'(pending_vec);
          else if (idx == 5'd1) reg_rdata_o = DATA_W'(claimed_vec);
        end
        default: reg_rdata_o = '0;
      endcase
    end
  end

  // ---------------- assertions ----------------
  // R6: a rejected completion leaves every in-service bit as it was
  a_r6_rejected_complete_no_effect: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_claim && !cmpl_ok && !claim_fire) |=> $stable(claimed_vec));

  // R7: auto-mask clears the claimed source's enable for the claiming context
  a_r7_automask_clears_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (claim_fire && auto_mask_i) |=> !en_q[$past(ctx_idx)][$past(claim_id)]);

  // R7: standard mode claim leaves enables alone
  a_r7_standard_keeps_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (claim_fire && !auto_mask_i && !en_wr) |=> $stable(en_q));

  // R9/R3: an interrupt line always has a real source behind it
  for (genvar c = 0; c < NUM_CTX; c++) begin : g_irq_chk
    a_r9_irq_has_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_o[c] |-> (best_id[c] != '0 && pending_vec[best_id[c]]));
  end

endmodule

// File: tb/test_irq_claim_ctrl.sv
module test_irq_claim_ctrl;

  localparam int NSRC = 31;
  localparam int NCTX = 2;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              auto_mask = 1'b0;
  logic [NSRC:1]     src = '0;
  logic              reg_rd = 1'b0, reg_wr = 1'b0;
  logic [7:0]        reg_addr = '0;
  logic [31:0]       reg_wdata = '0;
  logic [31:0]       reg_rdata;
  logic [NCTX-1:0]   irq;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  always #10 clk = ~clk;   // 50 MHz

  irq_claim_ctrl i_irq_claim_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .auto_mask_i(auto_mask), .src_i(src),
    .reg_rd_i(reg_rd), .reg_wr_i(reg_wr), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .irq_o(irq)
  );

  function automatic logic [7:0] a_prio(int s);  return 8'(s);        endfunction
  function automatic logic [7:0] a_en(int c);    return 8'h20 + 8'(c); endfunction
  function automatic logic [7:0] a_thr(int c);   return 8'h40 + 8'(c); endfunction
  function automatic logic [7:0] a_claim(int c); return 8'h60 + 8'(c); endfunction
  localparam logic [7:0] A_PEND = 8'h80;
  localparam logic [7:0] A_SVC  = 8'h81;

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  // All register tasks start and end at a falling edge.
  task automatic rd(logic [7:0] a, output logic [31:0] d);
    reg_rd = 1'b1; reg_addr = a;
    #2 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_chk(string req, logic [7:0] a, logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    chk(req, d, exp);
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R1 irq", 32'(irq), 0);
    rd_chk("R1 claim ctx0", a_claim(0), 0);
    rd_chk("R1 prio", a_prio(3), 0);
    rd_chk("R1 enable ctx1", a_en(1), 0);
    rd_chk("R1 pending", A_PEND, 0);
  endtask

  task automatic t_regs;
    wr(a_prio(6), 5);        rd_chk("R11 prio readback", a_prio(6), 5);
    wr(a_prio(6), 32'hF3);   rd_chk("R11 prio width", a_prio(6), 3);
    wr(a_en(1), '1);         rd_chk("R11 enable bit0 zero", a_en(1), 32'hFFFF_FFFE);
    wr(a_thr(0), 2);         rd_chk("R11 threshold", a_thr(0), 2);
    wr(a_prio(0), 7);        rd_chk("R11 prio0 fixed", a_prio(0), 0);
    wr(a_en(1), 0); wr(a_thr(0), 0); wr(a_prio(6), 0);
  endtask

  task automatic t_arbitration;
    wr(a_prio(2), 5); wr(a_prio(9), 5); wr(a_prio(5), 3); wr(a_prio(7), 0);
    wr(a_en(0), 32'h2A4);
    src[2] = 1; src[5] = 1; src[7] = 1; src[9] = 1;
    idle(2);
    rd_chk("R11 pending bits", A_PEND, 32'h2A4);
    chk("R9 irq raised", 32'(irq[0]), 1);
    rd_chk("R2 tie lowest id", a_claim(0), 2);
    rd_chk("R2 next highest", a_claim(0), 9);
    rd_chk("R2 lower priority", a_claim(0), 5);
    rd_chk("R3 prio0 not claimed", a_claim(0), 0);
    rd_chk("R4 in service set", A_SVC, 32'h224);
    rd_chk("R3 prio0 still pending", A_PEND, 32'h80);
    chk("R3 no irq for prio0", 32'(irq[0]), 0);
    src = '0;
    wr(a_claim(0), 2); wr(a_claim(0), 9); wr(a_claim(0), 5);
    rd_chk("R5 all completed", A_SVC, 0);
    wr(a_prio(7), 1);
    rd_chk("R3 claimable after prio", a_claim(0), 7);
    wr(a_claim(0), 7);
    wr(a_en(0), 0);
  endtask

  task automatic t_hold;
    wr(a_prio(3), 4); wr(a_en(0), 32'h8);
    src[3] = 1;
    idle(2);
    rd_chk("R4 claim", a_claim(0), 3);
    idle(3);
    rd_chk("R4 no re-pend in service", A_PEND, 0);
    rd_chk("R4 in service", A_SVC, 32'h8);
    wr(a_claim(0), 3);
    rd_chk("R5 not pending at completion edge", A_PEND, 0);
    rd_chk("R5 re-pend next edge", A_PEND, 32'h8);
    rd_chk("R5 service cleared", A_SVC, 0);
    src[3] = 0;
    rd_chk("R5 re-claim", a_claim(0), 3);
    wr(a_claim(0), 3);
    wr(a_en(0), 0);
  endtask

  task automatic t_ignore;
    wr(a_prio(4), 2); wr(a_en(0), 32'h10); wr(a_en(1), 0);
    src[4] = 1;
    idle(2);
    rd_chk("R6 claim", a_claim(0), 4);
    src[4] = 0;
    wr(a_claim(1), 4);
    rd_chk("R6 not enabled in ctx", A_SVC, 32'h10);
    wr(a_claim(0), 0);
    rd_chk("R6 id zero", A_SVC, 32'h10);
    wr(a_claim(0), 32'h24);
    rd_chk("R6 out of range", A_SVC, 32'h10);
    wr(a_claim(0), 4);
    rd_chk("R6 valid completes", A_SVC, 0);
    wr(a_en(0), 0);
  endtask

  task automatic t_automask;
    auto_mask = 1'b1;
    wr(a_prio(4), 2); wr(a_en(0), 32'h10);
    src[4] = 1;
    idle(2);
    rd_chk("R7 claim automask", a_claim(0), 4);
    rd_chk("R7 enable cleared", a_en(0), 0);
    src[4] = 0;
    wr(a_claim(0), 4);
    rd_chk("R8 stuck in service", A_SVC, 32'h10);
    wr(a_en(0), 32'h10);
    wr(a_claim(0), 4);
    rd_chk("R8 released after re-enable", A_SVC, 0);
    auto_mask = 1'b0;
    src[4] = 1;
    idle(2);
    rd_chk("R7 claim standard", a_claim(0), 4);
    rd_chk("R7 enable kept", a_en(0), 32'h10);
    src[4] = 0;
    wr(a_claim(0), 4);
    rd_chk("R7 cleanup", A_SVC, 0);
    wr(a_en(0), 0);
  endtask

  task automatic t_threshold;
    wr(a_prio(4), 3); wr(a_en(0), 32'h10); wr(a_thr(0), 3);
    src[4] = 1;
    idle(2);
    chk("R9 equal to threshold", 32'(irq[0]), 0);
    wr(a_thr(0), 2);
    chk("R9 above threshold", 32'(irq[0]), 1);
    chk("R9 other ctx idle", 32'(irq[1]), 0);
    rd_chk("R9 claim", a_claim(0), 4);
    chk("R9 dropped after claim", 32'(irq[0]), 0);
    src[4] = 0;
    wr(a_claim(0), 4);
    wr(a_thr(0), 0); wr(a_en(0), 0);
  endtask

  task automatic t_contexts;
    wr(a_prio(4), 3); wr(a_prio(8), 2);
    wr(a_en(0), 32'h110); wr(a_en(1), 32'h110);
    src[4] = 1; src[8] = 1;
    idle(2);
    chk("R10 both irq", 32'(irq), 3);
    rd_chk("R10 ctx0 claim", a_claim(0), 4);
    rd_chk("R10 ctx1 gets other", a_claim(1), 8);
    rd_chk("R10 ctx1 nothing left", a_claim(1), 0);
    src = '0;
    wr(a_claim(1), 4);
    rd_chk("R10 cross-context complete", A_SVC, 32'h100);
    wr(a_claim(0), 8);
    rd_chk("R10 all done", A_SVC, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_arbitration();
    t_hold();
    t_ignore();
    t_automask();
    t_threshold();
    t_contexts();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      checks++;
      failures++;
      $display("FAIL watchdog: got %0d cycles expected completion", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule